// File: doc/BRIEF.md
# Paged Burst Write Cache

This block sits between a serial-bus front end and a byte-addressed nonvolatile array whose cells are programmed one page at a time. A burst opens with a start pulse that carries a byte address. Each byte that follows is taken into a small cache. A stop pulse closes the burst. The controller then writes the cache out to the array, one page per timed programming cycle, and enables only the bytes that were actually received.

The cache holds `CACHE_PAGES` pages of `PAGE_BYTES` bytes each. A burst always starts filling cache page 0, at the byte offset taken from the low address bits. The fill pointer runs through the whole cache and wraps back onto the head of page 0. During the commit, cache page k goes to array page (start page + k). The array page number wraps at the top of the address space. A programmable cycle count stands in for the programming time of one page. While the commit runs, the busy flag is high and all burst inputs are ignored.

Top module: `wcache_ctrl`

## Requirements
- R1: Out of reset, `busy` and `arr_we` are low.
- R2: The first byte of a burst goes into cache page 0, at byte offset `wr_addr[2:0]`. Each following byte takes the next cache slot. Slot s is held in cache page s/8, at byte s%8.
- R3: After slot 63 the fill pointer returns to slot 0. A burst that starts at a nonzero offset therefore fills the head bytes of page 0 last.
- R4: When more than 64 bytes arrive before the stop, a wrapped byte replaces the byte held in its slot. The last value written to a slot is the value committed.
- R5: An accepted stop with data starts the commit. `arr_we` pulses in the first cycle after the stop edge. Cache page k is written to array page `(wr_addr[12:3] + k) mod 1024`.
- R6: Each committed page takes exactly `PAGE_CYCLES` cycles. `arr_we` is high only in the first of those cycles. Pages are committed from page 0 onward, up to the last page that holds a loaded byte. `busy` is high for `PAGE_CYCLES` times the committed page count, then drops.
- R7: During a page strobe, bit i of `arr_be` is set exactly when byte offset i of that cache page was loaded. For each enabled byte, `arr_data[8i+7:8i]` carries that byte.
- R8: While `busy` is high, `wr_start`, `byte_vld` and `stop` have no effect. The running commit continues unchanged, and nothing is loaded into the cache.
- R9: A stop with no byte loaded causes no strobe and no busy time.
- R10: A write start clears all loaded-byte marks. Marks are also cleared when a commit finishes, so a later stop without new bytes commits nothing.
- R11: A byte that arrives in the same cycle as a write start becomes the first byte of the new burst. A byte that arrives in the same cycle as the stop is included in the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Opens a burst at `wr_addr` |
| wr_addr | input | 13 | Start byte address |
| byte_vld | input | 1 | A burst byte is presented |
| byte_dat | input | 8 | Burst byte value |
| stop | input | 1 | Closes the burst and starts the commit |
| arr_we | output | 1 | One-cycle strobe at the start of each page cycle |
| arr_page | output | 10 | Array page being programmed |
| arr_data | output | 64 | Page data, byte i at bits 8i+7:8i |
| arr_be | output | 8 | Per-byte write enable |
| busy | output | 1 | Commit in progress |

## Verification
Three pairs of inputs can fall in the same cycle, and each pair interacts. A write start can share a cycle with a byte, and so can a stop. A byte or start can also arrive while a page cycle is running. The sweep alternates the start-with-byte and stop-with-byte forms across every start offset and a range of burst lengths. A bench model places each byte into its slot and derives each page's expected mask, data and array page number. Start, byte and stop pulses are also injected in the middle of the first page cycle. They must change neither the later page numbers nor the data, and after the commit a bare stop must produce no strobe.

// File: rtl/wcache_pkg.sv
package wcache_pkg;
   typedef enum logic [0:0] {
      WC_IDLE = 1'b0,
      WC_PROG = 1'b1
   } wc_state_e;
endpackage

// File: rtl/wcache_store.sv
module wcache_store #(
   parameter int BYTE_W      = 8,
   parameter int PAGE_BYTES  = 8,
   parameter int CACHE_PAGES = 8,
   localparam int SLOTS  = PAGE_BYTES * CACHE_PAGES,
   localparam int PTR_W  = $clog2(SLOTS),
   localparam int OFS_W  = $clog2(PAGE_BYTES),
   localparam int CP_W   = $clog2(CACHE_PAGES),
   localparam int PAGE_W = BYTE_W * PAGE_BYTES
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [OFS_W-1:0]       start_ofs,
   input  logic                   load,
   input  logic [BYTE_W-1:0]      load_dat,
   input  logic                   clear,
   input  logic [CP_W-1:0]        rd_page,
   output logic [PAGE_W-1:0]      rd_data,
   output logic [PAGE_BYTES-1:0]  rd_be,
   output logic [CACHE_PAGES-1:0] page_used
);
   if (SLOTS != (1 << PTR_W)) begin : g_bad_slots
      $error("wcache_store: cache slot count must be a power of two");
   end
   if (PAGE_BYTES != (1 << OFS_W)) begin : g_bad_page
      $error("wcache_store: PAGE_BYTES must be a power of two");
   end

   logic [PTR_W-1:0]        ptr_q;
   logic [PTR_W-1:0]        slot;
   logic [SLOTS-1:0]        vld_q, vld_d;
   logic [SLOTS*BYTE_W-1:0] mem_q;

   // a start restarts the fill at page 0, at the requested byte offset
   assign slot = start ? PTR_W'(start_ofs) : ptr_q;

   always_comb begin
      vld_d = start ? '0 : vld_q;
      if (load) vld_d[slot] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         vld_q <= '0;
      end else begin
         if (load)       ptr_q <= slot + 1'b1;
         else if (start) ptr_q <= slot;
         if (clear)      vld_q <= '0;
         else            vld_q <= vld_d;
      end
   end

   always_ff @(posedge clk) begin
      if (load) mem_q[slot*BYTE_W +: BYTE_W] <= load_dat;
   end

   for (genvar g = 0; g < CACHE_PAGES; g++) begin : g_page
      assign page_used[g] = |vld_q[g*PAGE_BYTES +: PAGE_BYTES];
   end

   assign rd_data = mem_q[rd_page*PAGE_W +: PAGE_W];
   assign rd_be   = vld_q[rd_page*PAGE_BYTES +: PAGE_BYTES];

   // R3: the fill pointer wraps from the last slot to slot 0
   a_r3_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !start && ptr_q == PTR_W'(SLOTS-1)) |=> (ptr_q == '0));
   // R8: cache contents change only on a load
   a_r8_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && $past(load)) |=> $stable(vld_q) || clear || start);
endmodule

// File: rtl/wcache_commit.sv
module wcache_commit
   import wcache_pkg::*;
#(
   parameter int CACHE_PAGES = 8,
   parameter int PAGE_CYCLES = 500000,
   localparam int CP_W  = $clog2(CACHE_PAGES),
   localparam int TMR_W = (PAGE_CYCLES > 1) ? $clog2(PAGE_CYCLES) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   go,
   input  logic [CACHE_PAGES-1:0] page_used,
   output logic                   busy,
   output logic                   we,
   output logic                   clear,
   output logic [CP_W-1:0]        pg_idx
);
   if (PAGE_CYCLES < 2) begin : g_bad_cycles
      $error("wcache_commit: PAGE_CYCLES must be at least 2");
   end

   wc_state_e        st_q;
   logic [TMR_W-1:0] tmr_q;
   logic [CP_W-1:0]  idx_q, idx_nx;
   logic             last_tick, more;

   assign idx_nx    = idx_q + 1'b1;
   assign last_tick = (st_q == WC_PROG) && (tmr_q == TMR_W'(PAGE_CYCLES-1));
   assign more      = (idx_q != CP_W'(CACHE_PAGES-1)) && page_used[idx_nx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= WC_IDLE;
         tmr_q <= '0;
         idx_q <= '0;
      end else if (st_q == WC_IDLE) begin
         if (go) begin
            st_q  <= WC_PROG;
            tmr_q <= '0;
            idx_q <= '0;
         end
      end else if (last_tick) begin
         tmr_q <= '0;
         if (more) idx_q <= idx_nx;
         else      st_q  <= WC_IDLE;
      end else begin
         tmr_q <= tmr_q + 1'b1;
      end
   end

   assign busy   = (st_q == WC_PROG);
   assign we     = busy && (tmr_q == '0);
   assign clear  = last_tick && !more;
   assign pg_idx = idx_q;

   // R6: the page strobe lasts a single cycle
   a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> !we);
   // R6: busy only ends at the close of a full page cycle
   a_r6_busy_span: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(tmr_q) == TMR_W'(PAGE_CYCLES-1)));
endmodule

// File: rtl/wcache_ctrl.sv
module wcache_ctrl #(
   parameter int ADDR_W      = 13,
   parameter int BYTE_W      = 8,
   parameter int PAGE_BYTES  = 8,
   parameter int CACHE_PAGES = 8,
   parameter int PAGE_CYCLES = 500000,
   localparam int OFS_W  = $clog2(PAGE_BYTES),
   localparam int PA_W   = ADDR_W - OFS_W,
   localparam int CP_W   = $clog2(CACHE_PAGES),
   localparam int PAGE_W = BYTE_W * PAGE_BYTES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_start,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic                  byte_vld,
   input  logic [BYTE_W-1:0]     byte_dat,
   input  logic                  stop,
   output logic                  arr_we,
   output logic [PA_W-1:0]       arr_page,
   output logic [PAGE_W-1:0]     arr_data,
   output logic [PAGE_BYTES-1:0] arr_be,
   output logic                  busy
);
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("wcache_ctrl: ADDR_W must exceed the page offset width");
   end

   logic                   acc_start, acc_load, go, clear, has_data;
   logic [CACHE_PAGES-1:0] used;
   logic [CP_W-1:0]        idx;
   logic [PA_W-1:0]        base_q;

   assign acc_start = wr_start && !busy;
   assign acc_load  = byte_vld && !busy;
   assign has_data  = acc_load || ((|used) && !acc_start);
   assign go        = stop && !busy && has_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         base_q <= '0;
      else if (acc_start) base_q <= wr_addr[ADDR_W-1:OFS_W];
   end

   wcache_store #(
      .BYTE_W(BYTE_W), .PAGE_BYTES(PAGE_BYTES), .CACHE_PAGES(CACHE_PAGES)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .start(acc_start), .start_ofs(wr_addr[OFS_W-1:0]),
      .load(acc_load), .load_dat(byte_dat),
      .clear(clear), .rd_page(idx),
      .rd_data(arr_data), .rd_be(arr_be), .page_used(used)
   );

   wcache_commit #(
      .CACHE_PAGES(CACHE_PAGES), .PAGE_CYCLES(PAGE_CYCLES)
   ) u_commit (
      .clk(clk), .rst_n(rst_n), .go(go), .page_used(used),
      .busy(busy), .we(arr_we), .clear(clear), .pg_idx(idx)
   );

   // the sum wraps past the top array page
   assign arr_page = base_q + PA_W'(idx);

   // R8: the start page stays fixed for the whole commit
   a_r8_base_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(base_q));
   // R7: a committed page always enables at least one byte
   a_r7_be_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> (|arr_be));
endmodule

// File: tb/wcache_ctrl_test.sv
module wcache_ctrl_test;
   localparam int PC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_start = 1'b0;
   logic [12:0] wr_addr = '0;
   logic        byte_vld = 1'b0;
   logic [7:0]  byte_dat = '0;
   logic        stop = 1'b0;
   logic        arr_we;
   logic [9:0]  arr_page;
   logic [63:0] arr_data;
   logic [7:0]  arr_be;
   logic        busy;

   int tests = 0;
   int fails = 0;

   logic [7:0] m_dat [64];
   logic       m_vld [64];
   int         m_ptr;
   int         m_base;

   wcache_ctrl #(.PAGE_CYCLES(PC)) uut (
      .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
      .byte_vld(byte_vld), .byte_dat(byte_dat), .stop(stop),
      .arr_we(arr_we), .arr_page(arr_page), .arr_data(arr_data),
      .arr_be(arr_be), .busy(busy)
   );

   always #5 clk = ~clk;

   initial begin
      #1500000;
      fails++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] gen(input int seed, input int i);
      return 8'((seed * 37 + i * 11 + 5) & 255);
   endfunction

   task automatic m_load(input logic [7:0] d);
      m_dat[m_ptr] = d;
      m_vld[m_ptr] = 1'b1;
      m_ptr = (m_ptr + 1) % 64;
   endtask

   // at the negedge just after the stop edge: check the whole commit
   task automatic check_commit(input bit inject);
      int npg = 0;
      for (int p = 0; p < 8; p++) begin
         bit any = 1'b0;
         for (int b = 0; b < 8; b++) any |= m_vld[p*8+b];
         if (any && npg == p) npg = p + 1;
      end
      if (npg == 0) begin
         for (int c = 0; c < 2; c++) begin
            chk(!busy && !arr_we, "R9 empty stop", {busy, arr_we}, 0);
            @(negedge clk);
         end
      end else begin
         for (int p = 0; p < npg; p++) begin
            for (int c = 0; c < PC; c++) begin
               chk(busy, "R6 busy", busy, 1);
               chk(arr_we == (c == 0), "R6 strobe", arr_we, (c == 0));
               if (c == 0) begin
                  logic [7:0] ebe = '0;
                  for (int b = 0; b < 8; b++) ebe[b] = m_vld[p*8+b];
                  chk(arr_page == 10'((m_base + p) % 1024), "R5 page", arr_page, (m_base + p) % 1024);
                  chk(arr_be == ebe, "R7 mask", arr_be, ebe);
                  for (int b = 0; b < 8; b++)
                     if (m_vld[p*8+b])
                        chk(arr_data[b*8 +: 8] == m_dat[p*8+b], "R2 R3 R4 data",
                            arr_data[b*8 +: 8], m_dat[p*8+b]);
               end
               if (inject && p == 0 && c == 1) begin
                  wr_start = 1'b1; wr_addr = 13'h1abc;
                  byte_vld = 1'b1; byte_dat = 8'h5a; stop = 1'b1;
               end
               @(negedge clk);
               wr_start = 1'b0; byte_vld = 1'b0; stop = 1'b0;
            end
         end
         chk(!busy && !arr_we, "R6 end of busy", {busy, arr_we}, 0);
      end
      for (int s = 0; s < 64; s++) m_vld[s] = 1'b0;
   endtask

   task automatic burst(input int addr, input int n, input bit cs, input bit cp,
                        input int seed, input bit inject);
      int i0 = 0;
      for (int s = 0; s < 64; s++) m_vld[s] = 1'b0;
      m_ptr  = addr % 8;
      m_base = (addr / 8) % 1024;
      wr_start = 1'b1; wr_addr = 13'(addr);
      if (cs && n > 0) begin
         byte_vld = 1'b1; byte_dat = gen(seed, 0); m_load(byte_dat); i0 = 1;
      end
      @(negedge clk);
      wr_start = 1'b0; byte_vld = 1'b0;
      for (int i = i0; i < n; i++) begin
         byte_vld = 1'b1; byte_dat = gen(seed, i); m_load(byte_dat);
         if (cp && i == n - 1) stop = 1'b1;
         @(negedge clk);
         byte_vld = 1'b0; stop = 1'b0;
      end
      if (!(cp && n > i0)) begin
         stop = 1'b1;
         @(negedge clk);
         stop = 1'b0;
      end
      check_commit(inject);
   endtask

   initial begin
      int lens [10] = '{0, 1, 5, 8, 9, 33, 63, 64, 65, 71};
      for (int s = 0; s < 64; s++) begin m_vld[s] = 1'b0; m_dat[s] = '0; end
      #23;
      chk(!busy && !arr_we, "R1 reset", {busy, arr_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !arr_we, "R1 after reset", {busy, arr_we}, 0);
      // R2 R3 R4 R11 sweep: every offset, many lengths, both same-cycle forms
      for (int off = 0; off < 8; off++)
         for (int li = 0; li < 10; li++) begin
            int pg = (off * 131 + li * 17) % 1024;
            burst(pg * 8 + off, lens[li], li % 2 == 1, off % 2 == 1,
                  off * 10 + li, li == 3 || li == 7);
         end
      // R5 wrap past the top array page
      burst(1021 * 8 + 3, 64, 1'b0, 1'b0, 99, 1'b0);
      burst(1023 * 8 + 7, 20, 1'b1, 1'b1, 77, 1'b1);
      // R10: after a commit, a bare stop commits nothing
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      check_commit(1'b0);
      // R10: a new start drops earlier marks; then a bare stop is empty
      burst(40, 3, 1'b0, 1'b0, 5, 1'b0);
      wr_start = 1'b1; wr_addr = 13'd200;
      @(negedge clk);
      wr_start = 1'b0; stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      check_commit(1'b0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule